// File: doc/BRIEF.md
# Acquisition Search Order Sequencer

This block drives a bank of correlator channels during a warm-start signal search, when the carrier frequency is already known. The only unknowns left are which satellite codes are present and where in code delay they sit. A satellite list memory holds the code seed of each candidate. The sequencer hands each channel a seed and a starting delay offset. Each channel then covers `TAPS` consecutive delay positions in one dump. The sequencer waits until every started channel has reported its dump and detect result, and then plans the next step.

Two search orders are offered, and the choice is sampled at start. In the delays-first order, every channel works on the same satellite and the channels tile the delay axis. The block exhausts one satellite before it moves to the next. In the satellites-first order, each channel takes a different pending satellite at a shared delay block. The block goes through the whole list before it moves the delay block forward. A satellite that has been found is dropped from later steps. Each find is written to a small results FIFO as a seed and offset pair. The run ends with a done flag once a programmed number of finds is reached, or, with an incomplete status, once the search space is exhausted.

Top module: `acq_search_seq`

## Requirements
- R1: After reset, `ch_start`, `done`, `incomplete` and `res_valid` are all 0.
- R2: With `order`=0 (delays first), every channel started in a step gets the same satellite. Channel j gets offset base + j*TAPS, and a channel whose offset is not below `delay_space` stays idle. The base starts at 0 and grows by TAPS*NUM_CH per step. The search moves to the next list entry, with base 0, once the current satellite is found or once base + TAPS*NUM_CH is not below `delay_space`.
- R3: With `order`=1 (satellites first), channels 0, 1, ... take successive not-yet-found list entries, in list order, all at the same base. If the end of the list is reached after at least one channel is filled, the remaining channels stay idle for that step. If the end is reached before any channel is filled, the scan restarts at entry 0 with base + TAPS.
- R4: Started channels are flagged by a one-cycle `ch_start` pulse, with `ch_seed` and `ch_offset` valid in the same cycle. No new pulse is issued until every started channel has pulsed `ch_dump`, in any order and in any cycles. `ch_detect` is sampled in a channel's dump cycle.
- R5: A started channel reports a detect. If its satellite is not yet found and the find count is below `det_target`, one FIFO entry {seed, that channel's offset} is written. Channels are handled in ascending index order within a step. The satellite is never assigned again in that run.
- R6: When the find count reaches `det_target`, no further step starts. `done` goes to 1 with `incomplete`=0, and the FIFO holds exactly `det_target` entries.
- R7: If the space is exhausted first, `done` goes to 1 with `incomplete`=1. In the delays-first order this happens when the list runs out. In the satellites-first order it happens when base + TAPS is not below `delay_space` at a list wrap.
- R8: `order`, `num_sats`, `delay_space` and `det_target` are sampled on an accepted `start`. `start` is ignored while a run is in progress. A `start` after `done` clears `done`, `incomplete` and the FIFO, and begins a new run.
- R9: `res_valid` is 1 while the FIFO holds an entry, with `res_seed` and `res_offset` showing the oldest entry. A one-cycle `res_pop` removes that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| order | input | 1 | 0 = delays first, 1 = satellites first |
| num_sats | input | SAT_W+1 | Number of valid list entries |
| delay_space | input | DLY_W | Total delay positions to search |
| det_target | input | TGT_W | Finds that end the run |
| lst_we | input | 1 | Satellite list write enable |
| lst_addr | input | SAT_W | Satellite list write address |
| lst_seed | input | SEED_W | Code seed written to the list |
| ch_start | output | NUM_CH | One-cycle start pulse per channel |
| ch_seed | output | NUM_CH*SEED_W | Code seed per channel, channel j at bits j*SEED_W |
| ch_offset | output | NUM_CH*DLY_W | Start delay per channel, channel j at bits j*DLY_W |
| ch_dump | input | NUM_CH | Channel finished its dump |
| ch_detect | input | NUM_CH | Channel detect result, valid with its dump |
| res_pop | input | 1 | Remove oldest result |
| res_valid | output | 1 | Result FIFO not empty |
| res_seed | output | SEED_W | Seed of oldest result |
| res_offset | output | DLY_W | Delay offset of oldest result |
| done | output | 1 | Run finished |
| incomplete | output | 1 | Run finished with fewer finds than requested |

## Verification
A corrupted base, scan pointer or found-mask shows at the very next `ch_start` pulse as a wrong seed, a wrong offset or a wrong active mask on some channel, so each step is compared against the expected assignment. A miscounted find count or a missed exhaustion test shows only at the end of the run: `done` is raised too early or too late, `incomplete` has the wrong value, or the FIFO holds a different number of entries. Each run is therefore closed by checking `done`, then `incomplete`, then the FIFO contents. A lost dump latch shows as a hang: no further pulse is issued.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SEEK, S_ASSIGN, S_LAUNCH, S_WAIT, S_EVAL, S_ADV, S_DONE
  } seq_st_e;

  typedef enum logic {
    ORD_DLY_FIRST = 1'b0,
    ORD_SAT_FIRST = 1'b1
  } ord_e;
endpackage

// File: rtl/acq_sat_list.sv
module acq_sat_list #(
  parameter int DEPTH = 32,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acq_result_fifo.sv
module acq_result_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 26,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         valid,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic do_push, do_pop;

  assign valid   = (cnt != '0);
  assign full    = (cnt == (PW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      if (do_push && !do_pop)      cnt <= cnt + (PW+1)'(1);
      else if (do_pop && !do_push) cnt <= cnt - (PW+1)'(1);
    end
  end
endmodule

// File: rtl/acq_search_seq.sv
module acq_search_seq
  import acq_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int TAPS       = 32,
  parameter int LIST_DEPTH = 32,
  parameter int SEED_W     = 10,
  parameter int DLY_W      = 16,
  parameter int TGT_W      = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int SAT_W     = $clog2(LIST_DEPTH),
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SUM_W     = DLY_W + 1,
  localparam int STEP      = TAPS * NUM_CH
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     order,
  input  logic [SAT_W:0]           num_sats,
  input  logic [DLY_W-1:0]         delay_space,
  input  logic [TGT_W-1:0]         det_target,
  input  logic                     lst_we,
  input  logic [SAT_W-1:0]         lst_addr,
  input  logic [SEED_W-1:0]        lst_seed,
  output logic [NUM_CH-1:0]        ch_start,
  output logic [NUM_CH*SEED_W-1:0] ch_seed,
  output logic [NUM_CH*DLY_W-1:0]  ch_offset,
  input  logic [NUM_CH-1:0]        ch_dump,
  input  logic [NUM_CH-1:0]        ch_detect,
  input  logic                     res_pop,
  output logic                     res_valid,
  output logic [SEED_W-1:0]        res_seed,
  output logic [DLY_W-1:0]         res_offset,
  output logic                     done,
  output logic                     incomplete
);
  localparam logic [CH_W-1:0] K_LAST = CH_W'(NUM_CH - 1);

  seq_st_e st;
  ord_e    ord_q;
  logic [SAT_W:0]     n_q, s_cur;
  logic [DLY_W-1:0]   space_q, d_cur;
  logic [TGT_W-1:0]   tgt_q, det_cnt;
  logic [CH_W-1:0]    k, rd_k_q;
  logic               rd_v_q, done_r, inc_r;
  logic [NUM_CH-1:0]  act_r, pend_r, hit_r, start_r;
  logic [LIST_DEPTH-1:0] det_flag;
  logic [SEED_W-1:0]  seed_r [NUM_CH];
  logic [DLY_W-1:0]   off_r  [NUM_CH];
  logic [SAT_W-1:0]   sidx_r [NUM_CH];

  logic [SEED_W-1:0]  list_q;
  logic [SAT_W-1:0]   s_idx, e_sidx;
  logic               in_list, rec, run_go, fifo_full;
  logic [SUM_W-1:0]   k_off, blk_next, step_next, space_w;

  assign s_idx     = s_cur[SAT_W-1:0];
  assign in_list   = (s_cur < n_q);
  assign space_w   = SUM_W'(space_q);
  assign k_off     = SUM_W'(d_cur) + SUM_W'(k) * SUM_W'(TAPS);
  assign blk_next  = SUM_W'(d_cur) + SUM_W'(TAPS);
  assign step_next = SUM_W'(d_cur) + SUM_W'(STEP);
  assign e_sidx    = sidx_r[k];
  assign rec       = (st == S_EVAL) && act_r[k] && hit_r[k] && !det_flag[e_sidx]
                     && (det_cnt < tgt_q) && !fifo_full;
  assign run_go    = start && ((st == S_IDLE) || (st == S_DONE));

  acq_sat_list #(.DEPTH(LIST_DEPTH), .W(SEED_W)) u_list (
    .clk(clk), .we(lst_we), .waddr(lst_addr), .wdata(lst_seed),
    .raddr(s_idx), .rdata(list_q)
  );

  acq_result_fifo #(.DEPTH(FIFO_DEPTH), .W(SEED_W + DLY_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(run_go), .push(rec),
    .din({seed_r[k], off_r[k]}), .pop(res_pop),
    .dout({res_seed, res_offset}), .valid(res_valid), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      ord_q <= ORD_DLY_FIRST;
      n_q <= '0; s_cur <= '0; space_q <= '0; d_cur <= '0;
      tgt_q <= '0; det_cnt <= '0; k <= '0; rd_k_q <= '0; rd_v_q <= 1'b0;
      done_r <= 1'b0; inc_r <= 1'b0;
      act_r <= '0; pend_r <= '0; hit_r <= '0; start_r <= '0; det_flag <= '0;
      for (int j = 0; j < NUM_CH; j++) begin
        seed_r[j] <= '0; off_r[j] <= '0; sidx_r[j] <= '0;
      end
    end else begin
      start_r <= '0;
      rd_v_q  <= 1'b0;
      if (rd_v_q) seed_r[rd_k_q] <= list_q;
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            ord_q <= ord_e'(order);
            n_q <= num_sats; space_q <= delay_space; tgt_q <= det_target;
            det_flag <= '0; det_cnt <= '0; s_cur <= '0; d_cur <= '0; k <= '0;
            act_r <= '0; done_r <= 1'b0; inc_r <= 1'b0;
            st <= (order == ORD_SAT_FIRST) ? S_ASSIGN : S_SEEK;
          end
        end
        S_SEEK: begin
          if (!in_list) begin
            done_r <= 1'b1; inc_r <= 1'b1; st <= S_DONE;
          end else if (det_flag[s_idx]) begin
            s_cur <= s_cur + 1'b1;
          end else begin
            k <= '0; st <= S_ASSIGN;
          end
        end
        S_ASSIGN: begin
          if (ord_q == ORD_DLY_FIRST) begin
            act_r[k]  <= (k_off < space_w);
            sidx_r[k] <= s_idx;
            off_r[k]  <= k_off[DLY_W-1:0];
            rd_v_q <= 1'b1; rd_k_q <= k;
            if (k == K_LAST) st <= S_LAUNCH;
            else k <= k + CH_W'(1);
          end else if (!in_list) begin
            if (k == '0) begin
              s_cur <= '0;
              if (blk_next >= space_w) begin
                done_r <= 1'b1; inc_r <= 1'b1; st <= S_DONE;
              end else begin
                d_cur <= blk_next[DLY_W-1:0];
              end
            end else begin
              st <= S_LAUNCH;
            end
          end else if (det_flag[s_idx]) begin
            s_cur <= s_cur + 1'b1;
          end else begin
            act_r[k]  <= 1'b1;
            sidx_r[k] <= s_idx;
            off_r[k]  <= d_cur;
            rd_v_q <= 1'b1; rd_k_q <= k;
            s_cur <= s_cur + 1'b1;
            if (k == K_LAST) st <= S_LAUNCH;
            else k <= k + CH_W'(1);
          end
        end
        S_LAUNCH: begin
          start_r <= act_r; pend_r <= act_r; hit_r <= '0;
          st <= S_WAIT;
        end
        S_WAIT: begin
          for (int j = 0; j < NUM_CH; j++) begin
            if (pend_r[j] && ch_dump[j]) begin
              pend_r[j] <= 1'b0;
              hit_r[j]  <= ch_detect[j];
            end
          end
          if ((pend_r & ~ch_dump) == '0) begin
            k <= '0; st <= S_EVAL;
          end
        end
        S_EVAL: begin
          if (rec) begin
            det_flag[e_sidx] <= 1'b1;
            det_cnt <= det_cnt + TGT_W'(1);
          end
          if (k == K_LAST) st <= S_ADV;
          else k <= k + CH_W'(1);
        end
        S_ADV: begin
          act_r <= '0; k <= '0;
          if (det_cnt >= tgt_q) begin
            done_r <= 1'b1; inc_r <= 1'b0; st <= S_DONE;
          end else if (ord_q == ORD_SAT_FIRST) begin
            st <= S_ASSIGN;
          end else if (det_flag[s_idx] || (step_next >= space_w)) begin
            s_cur <= s_cur + 1'b1; d_cur <= '0; st <= S_SEEK;
          end else begin
            d_cur <= step_next[DLY_W-1:0]; st <= S_ASSIGN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign ch_seed[g*SEED_W +: SEED_W] = seed_r[g];
    assign ch_offset[g*DLY_W +: DLY_W] = off_r[g];
  end

  assign ch_start   = start_r;
  assign done       = done_r;
  assign incomplete = inc_r;
endmodule

// File: rtl/acq_search_seq_chk.sv
module acq_search_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int TAPS   = 32,
  parameter int SEED_W = 10,
  parameter int DLY_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     run_go,
  input logic                     ord_q,
  input logic [DLY_W-1:0]         space_q,
  input logic [NUM_CH-1:0]        ch_start,
  input logic [NUM_CH*SEED_W-1:0] ch_seed,
  input logic [NUM_CH*DLY_W-1:0]  ch_offset,
  input logic                     res_valid,
  input logic                     res_pop,
  input logic                     done,
  input logic                     incomplete
);
  for (genvar j = 0; j < NUM_CH; j++) begin : g_space
    AST_OFFSET_IN_SPACE: assert property (@(posedge clk) disable iff (rst)
      ch_start[j] |-> (ch_offset[j*DLY_W +: DLY_W] < space_q)); // R2
  end

  for (genvar j = 1; j < NUM_CH; j++) begin : g_pair
    AST_DLY_FIRST_TILES: assert property (@(posedge clk) disable iff (rst)
      (!ord_q && ch_start[j] && ch_start[0]) |->
      ((ch_seed[j*SEED_W +: SEED_W] == ch_seed[0 +: SEED_W]) &&
       (ch_offset[j*DLY_W +: DLY_W] == ch_offset[0 +: DLY_W] + DLY_W'(j*TAPS)))); // R2
    AST_SAT_FIRST_SHARED_BASE: assert property (@(posedge clk) disable iff (rst)
      (ord_q && ch_start[j] && ch_start[0]) |->
      (ch_offset[j*DLY_W +: DLY_W] == ch_offset[0 +: DLY_W])); // R3
  end

  AST_NO_LAUNCH_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (ch_start == '0)); // R6
  AST_INCOMPLETE_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    incomplete |-> done); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !run_go) |=> done); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_pop && !run_go) |=> res_valid); // R9
endmodule

bind acq_search_seq acq_search_seq_chk #(
  .NUM_CH(NUM_CH), .TAPS(TAPS), .SEED_W(SEED_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst(rst), .run_go(run_go), .ord_q(ord_q), .space_q(space_q),
  .ch_start(ch_start), .ch_seed(ch_seed), .ch_offset(ch_offset),
  .res_valid(res_valid), .res_pop(res_pop), .done(done), .incomplete(incomplete)
);

// File: tb/tb_acq_search_seq.sv
module tb_acq_search_seq;
  localparam int NCH = 2;
  localparam int TP  = 4;
  localparam int LD  = 8;
  localparam int SW  = 10;
  localparam int DW  = 8;
  localparam int TW  = 4;
  localparam int FD  = 8;

  logic clk = 1'b0;
  logic rst, start, order, lst_we, res_pop;
  logic [3:0] num_sats;
  logic [DW-1:0] dspace;
  logic [TW-1:0] tgt;
  logic [2:0] lst_addr;
  logic [SW-1:0] lst_seed;
  logic [NCH-1:0] ch_start, ch_dump, ch_detect;
  logic [NCH*SW-1:0] ch_seed;
  logic [NCH*DW-1:0] ch_offset;
  logic res_valid, done, incomplete;
  logic [SW-1:0] res_seed;
  logic [DW-1:0] res_offset;

  int n_chk = 0;
  int n_fail = 0;
  int tdel [LD];

  always #4 clk = ~clk;

  acq_search_seq #(.NUM_CH(NCH), .TAPS(TP), .LIST_DEPTH(LD), .SEED_W(SW),
                   .DLY_W(DW), .TGT_W(TW), .FIFO_DEPTH(FD)) dut (
    .clk(clk), .rst(rst), .start(start), .order(order), .num_sats(num_sats),
    .delay_space(dspace), .det_target(tgt), .lst_we(lst_we), .lst_addr(lst_addr),
    .lst_seed(lst_seed), .ch_start(ch_start), .ch_seed(ch_seed), .ch_offset(ch_offset),
    .ch_dump(ch_dump), .ch_detect(ch_detect), .res_pop(res_pop), .res_valid(res_valid),
    .res_seed(res_seed), .res_offset(res_offset), .done(done), .incomplete(incomplete)
  );

  function automatic int seed_of(int s);
    return (s * 37 + 5) % 1024;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  task automatic wait_event(output bit got_launch, output bit got_done);
    got_launch = 0; got_done = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (ch_start != '0) begin got_launch = 1; return; end
      if (done) begin got_done = 1; return; end
    end
  endtask

  task automatic run_case(int ord, int n, int space, int tg, bit disturb, bit leave_one);
    int ms, md, cnt, k, step, exp_n;
    bit fin, m_inc, gl, gd;
    bit found [LD];
    int e_act [NCH];
    int e_sat [NCH];
    int e_off [NCH];
    int x_seed [16];
    int x_off [16];
    string rq;
    rq = (ord != 0) ? "R3" : "R2";
    for (int s = 0; s < LD; s++) found[s] = 0;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      lst_we = 1; lst_addr = 3'(s); lst_seed = SW'(seed_of(s));
    end
    @(negedge clk);
    lst_we = 0;
    order = ord[0]; num_sats = 4'(n); dspace = DW'(space); tgt = TW'(tg); start = 1;
    @(negedge clk);
    start = 0;
    check(res_valid == 0 && done == 0, "R8", "results and done cleared at start", res_valid, 0);
    ms = 0; md = 0; cnt = 0; fin = 0; m_inc = 0; exp_n = 0; step = 0;
    while (!fin && step < 300) begin
      for (int j = 0; j < NCH; j++) begin e_act[j] = 0; e_sat[j] = 0; e_off[j] = 0; end
      if (ord == 0) begin
        if (ms >= n) begin fin = 1; m_inc = 1; end
        else for (int j = 0; j < NCH; j++) begin
          e_sat[j] = ms; e_off[j] = md + j * TP; e_act[j] = (e_off[j] < space);
        end
      end else begin
        k = 0;
        while (!fin && k < NCH) begin
          if (ms >= n) begin
            if (k == 0) begin
              ms = 0;
              if (md + TP >= space) begin fin = 1; m_inc = 1; end
              else md = md + TP;
            end else break;
          end else if (found[ms]) ms++;
          else begin
            e_act[k] = 1; e_sat[k] = ms; e_off[k] = md; ms++; k++;
          end
        end
      end
      if (fin) break;
      wait_event(gl, gd);
      check(gl, rq, "step launch seen", gl, 1);
      if (!gl) return;
      for (int j = 0; j < NCH; j++) begin
        check(ch_start[j] == e_act[j][0], rq, $sformatf("step %0d ch%0d active", step, j),
              ch_start[j], e_act[j]);
        if (e_act[j] != 0) begin
          check(ch_seed[j*SW +: SW] == SW'(seed_of(e_sat[j])), rq,
                $sformatf("step %0d ch%0d seed", step, j), ch_seed[j*SW +: SW], seed_of(e_sat[j]));
          check(ch_offset[j*DW +: DW] == DW'(e_off[j]), rq,
                $sformatf("step %0d ch%0d offset", step, j), ch_offset[j*DW +: DW], e_off[j]);
        end
      end
      if (disturb && step == 0) begin
        order = ~order; start = 1;
        @(negedge clk);
        start = 0;
      end
      for (int j = NCH - 1; j >= 0; j--) begin
        if (e_act[j] != 0) begin
          ch_dump[j] = 1;
          ch_detect[j] = (tdel[e_sat[j]] >= e_off[j]) && (tdel[e_sat[j]] < e_off[j] + TP);
          @(negedge clk);
          ch_dump[j] = 0; ch_detect[j] = 0;
          @(negedge clk);
          if (j != 0) check(ch_start == '0, "R4", "no launch while dumps pending", ch_start, 0);
        end
      end
      for (int j = 0; j < NCH; j++) begin
        if (e_act[j] != 0 && tdel[e_sat[j]] >= e_off[j] && tdel[e_sat[j]] < e_off[j] + TP
            && !found[e_sat[j]] && cnt < tg) begin
          found[e_sat[j]] = 1; cnt++;
          x_seed[exp_n] = seed_of(e_sat[j]); x_off[exp_n] = e_off[j]; exp_n++;
        end
      end
      if (cnt >= tg) begin fin = 1; m_inc = 0; end
      else if (ord == 0) begin
        if (found[ms] || md + TP * NCH >= space) begin ms++; md = 0; end
        else md = md + TP * NCH;
      end
      step++;
    end
    wait_event(gl, gd);
    check(gd && !gl, m_inc ? "R7" : "R6", "run ends with done and no extra step", gd, 1);
    check(incomplete == m_inc, m_inc ? "R7" : "R6", "incomplete status", incomplete, m_inc);
    for (int i = 0; i < exp_n - (leave_one ? 1 : 0); i++) begin
      check(res_valid == 1, "R9", "entry present", res_valid, 1);
      check(res_seed == SW'(x_seed[i]), "R5", $sformatf("entry %0d seed", i), res_seed, x_seed[i]);
      check(res_offset == DW'(x_off[i]), "R5", $sformatf("entry %0d offset", i), res_offset, x_off[i]);
      res_pop = 1;
      @(negedge clk);
      res_pop = 0;
    end
    if (!leave_one) check(res_valid == 0, "R6", "no surplus entries", res_valid, 0);
  endtask

  initial begin
    rst = 1; start = 0; order = 0; lst_we = 0; res_pop = 0;
    num_sats = '0; dspace = '0; tgt = '0; lst_addr = '0; lst_seed = '0;
    ch_dump = '0; ch_detect = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(ch_start == '0, "R1", "ch_start after reset", ch_start, 0);
    check(done == 0 && incomplete == 0, "R1", "done/incomplete after reset", done, 0);
    check(res_valid == 0, "R1", "res_valid after reset", res_valid, 0);

    tdel[0] = 9; tdel[1] = -1; tdel[2] = 0; tdel[3] = 19; tdel[4] = 13;
    tdel[5] = -1; tdel[6] = -1; tdel[7] = -1;
    run_case(0, 5, 20, 4, 1, 0);
    run_case(1, 5, 20, 4, 1, 0);

    tdel[0] = -1; tdel[1] = 5; tdel[2] = -1;
    run_case(0, 3, 12, 4, 0, 1);

    tdel[0] = 10; tdel[1] = -1; tdel[2] = 1;
    run_case(1, 3, 12, 4, 0, 0);

    tdel[0] = 2; tdel[1] = 3; tdel[2] = -1; tdel[3] = -1;
    run_case(1, 4, 8, 1, 0, 0);

    tdel[0] = -1; tdel[1] = 6; tdel[2] = 30; tdel[3] = 1;
    run_case(0, 4, 32, 2, 0, 0);

    summary();
    $finish;
  end
endmodule